// File: doc/BRIEF.md
# Two-wire bus recovery sequencer

This block sits on the host side of a two-wire serial bus. Software uses it after power-up, or after a command was cut off part-way, to clear any target that may still hold the bus. A one-cycle request picks one of three recovery patterns. The block then plays that pattern on the clock line (SCL) and the data line (SDA) through open-drain enables. An enable of 1 pulls its line low. An enable of 0 releases the line to its pull-up. The block never drives a line high.

The patterns are built from three primitives, and each primitive is split into quarter periods:

- **Dummy clock:** the clock is low for quarters 0 and 3 and released for quarters 1 and 2. SDA stays released for the whole primitive, so a target that is still sending a low ACK or a low data bit never meets a driven high.
- **START:** in quarter 0, SCL is low and SDA is released. In quarter 1, SCL is released. In quarter 2, SDA is pulled low while SCL is high. In quarter 3, SCL is pulled low again. Because SDA is released while SCL is low, back-to-back STARTs each form a proper repeated START.
- **Closing phase:** after the last primitive, SCL is released while SDA is still low. Then SDA is released, which is a STOP condition. Both lines are left idle and `done_o` pulses, so a separate command engine can take over.

The state machine has four states:

- `K_IDLE` waits for a request.
- `K_DUMMY` plays dummy clocks.
- `K_START` plays STARTs.
- `K_FINISH` plays the closing phase.

It moves between states through these transitions:

- **accept:** `K_IDLE` moves to the first segment's state when a request arrives with a valid mode.
- **quarter step:** on each prescaler tick, the state advances by one quarter.
- **primitive step:** after quarter 3, the primitive counter advances.
- **segment step:** after the last primitive of a segment, the state moves to the next segment's state (`K_DUMMY`, `K_START` or `K_FINISH`).
- **finish:** at the end of quarter 1 of `K_FINISH`, the state returns to `K_IDLE` and `done_o` is raised.

A prescaler sets the length of each quarter to `DIV` system clocks.

Top module: `recov_seq`

## Requirements
- R1: Mode 2'b00 plays 14 dummy clocks (parameter `A_CLOCKS`), then two STARTs, then the closing STOP.
- R2: Mode 2'b01 plays one START, then 9 dummy clocks (parameter `B_CLOCKS`), then one START, then the closing STOP.
- R3: Mode 2'b10 plays 9 STARTs back to back (parameter `C_STARTS`), then the closing STOP.
- R4: During every dummy clock, `sda_oe_o` is 0 (SDA is released). Each dummy clock has SCL low, then high, then low. A START is SDA falling while SCL is high.
- R5: Each quarter lasts `DIV` system clocks, and lines change only on a quarter boundary or on accept. Let Q be the number of quarters, which is 4 per primitive plus 2 for the closing phase. Then `done_o` rises at clock edge Q*`DIV` after the accepting edge.
- R6: `done_o` is high for exactly one system clock per sequence.
- R7: The sequence ends with SCL released while SDA is low, then SDA released (a STOP). Both enables are 0 whenever `done_o` is high.
- R8: A request that arrives while a sequence is running is ignored: the running pattern and its length are unchanged, and no extra `done_o` pulse occurs.
- R9: A request with mode 2'b11 is ignored: both lines stay released and `done_o` stays 0.
- R10: While reset is active and afterwards, until a request is accepted, both enables and `done_o` are 0.
- R11: SCL and SDA never change in the same system clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Sequence request, sampled while idle |
| mode_i | input | 2 | Pattern select: 00, 01 or 10; 11 is invalid |
| scl_oe_o | output | 1 | 1 pulls SCL low |
| sda_oe_o | output | 1 | 1 pulls SDA low |
| done_o | output | 1 | One-cycle pulse when the bus has been handed back idle |

## Verification
The enables are decoded directly from the state registers. A request sampled on one edge therefore moves SCL low right after that edge. Each later line change comes exactly `DIV` clocks after the previous quarter boundary, and `done_o` is due Q*`DIV` edges after the accepting edge. The bench drives inputs and samples outputs on falling edges. It decodes the line activity into dummy clocks, STARTs and STOPs. It counts falling edges from the accepting edge to `done_o` and compares the count with Q*`DIV`, which it works out from the mode. It then reads `done_o` one edge later to confirm the pulse has dropped.

// File: rtl/recov_pkg.sv
package recov_pkg;
    typedef enum logic [1:0] {
        K_IDLE   = 2'd0,
        K_DUMMY  = 2'd1,
        K_START  = 2'd2,
        K_FINISH = 2'd3
    } rk_e;

    localparam logic [1:0] MODE_A    = 2'b00;
    localparam logic [1:0] MODE_B    = 2'b01;
    localparam logic [1:0] MODE_C    = 2'b10;
    localparam logic [1:0] MODE_NONE = 2'b11;
endpackage

// File: rtl/recov_tick.sv
module recov_tick #(
    parameter int DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    output logic tick
);
    localparam int W = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [W-1:0] LAST = W'(DIV - 1);

    logic [W-1:0] cnt;

    assign tick = en && (cnt == LAST);

    always_ff @(posedge clk) begin
        if (!rst_n || !en || tick) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + W'(1);
        end
    end
endmodule

// File: rtl/recov_prog.sv
module recov_prog
    import recov_pkg::*;
#(
    parameter int A_CLOCKS = 14,
    parameter int B_CLOCKS = 9,
    parameter int C_STARTS = 9,
    parameter int CW       = 4
) (
    input  logic [1:0]    mode,
    input  logic [1:0]    seg,
    output rk_e           cur_kind,
    output logic [CW-1:0] cur_cnt,
    output rk_e           nxt_kind
);
    typedef struct packed {
        rk_e           kind;
        logic [CW-1:0] cnt;
    } ent_t;

    function automatic ent_t lookup(input logic [1:0] m, input logic [1:0] s);
        ent_t e;
        e.kind = K_FINISH;
        e.cnt  = CW'(1);
        unique case (m)
            MODE_A: begin
                if (s == 2'd0) begin
                    e.kind = K_DUMMY;
                    e.cnt  = CW'(A_CLOCKS);
                end else if (s == 2'd1) begin
                    e.kind = K_START;
                    e.cnt  = CW'(2);
                end
            end
            MODE_B: begin
                if (s == 2'd0 || s == 2'd2) begin
                    e.kind = K_START;
                end else if (s == 2'd1) begin
                    e.kind = K_DUMMY;
                    e.cnt  = CW'(B_CLOCKS);
                end
            end
            MODE_C: begin
                if (s == 2'd0) begin
                    e.kind = K_START;
                    e.cnt  = CW'(C_STARTS);
                end
            end
            default: begin
                e.kind = K_FINISH;
            end
        endcase
        return e;
    endfunction

    ent_t cur_e;
    ent_t nxt_e;

    always_comb begin
        cur_e = lookup(mode, seg);
        nxt_e = lookup(mode, seg + 2'd1);
    end

    assign cur_kind = cur_e.kind;
    assign cur_cnt  = cur_e.cnt;
    assign nxt_kind = nxt_e.kind;
endmodule

// File: rtl/recov_fsm.sv
module recov_fsm
    import recov_pkg::*;
#(
    parameter int CW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    input  logic [1:0]    mode_i,
    input  logic          tick,
    input  rk_e           cur_kind,
    input  logic [CW-1:0] cur_cnt,
    input  rk_e           nxt_kind,
    output logic [1:0]    mode_sel,
    output logic [1:0]    seg,
    output logic          busy,
    output logic          accept,
    output logic          is_dummy,
    output logic          scl_oe,
    output logic          sda_oe,
    output logic          done
);
    rk_e           state, state_n;
    logic [1:0]    q, q_n;
    logic [CW-1:0] ops, ops_n;
    logic [1:0]    seg_n;
    logic [1:0]    mode_r, mode_n;
    logic          done_n;
    logic          q_last, op_last;

    assign busy     = (state != K_IDLE);
    assign is_dummy = (state == K_DUMMY);
    assign accept   = (state == K_IDLE) && start_i && (mode_i != MODE_NONE);
    assign mode_sel = (state == K_IDLE) ? mode_i : mode_r;
    assign q_last   = (state == K_FINISH) ? (q == 2'd1) : (q == 2'd3);
    assign op_last  = (ops == cur_cnt - CW'(1));

    always_comb begin
        state_n = state;
        q_n     = q;
        ops_n   = ops;
        seg_n   = seg;
        mode_n  = mode_r;
        done_n  = 1'b0;
        unique case (state)
            K_IDLE: begin
                if (accept) begin
                    state_n = cur_kind;
                    mode_n  = mode_i;
                    q_n     = 2'd0;
                    ops_n   = '0;
                    seg_n   = 2'd0;
                end
            end
            K_DUMMY, K_START: begin
                if (tick) begin
                    if (!q_last) begin
                        q_n = q + 2'd1;
                    end else begin
                        q_n = 2'd0;
                        if (!op_last) begin
                            ops_n = ops + CW'(1);
                        end else begin
                            ops_n   = '0;
                            seg_n   = seg + 2'd1;
                            state_n = nxt_kind;
                        end
                    end
                end
            end
            K_FINISH: begin
                if (tick) begin
                    if (!q_last) begin
                        q_n = q + 2'd1;
                    end else begin
                        state_n = K_IDLE;
                        q_n     = 2'd0;
                        seg_n   = 2'd0;
                        done_n  = 1'b1;
                    end
                end
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= K_IDLE;
            q      <= 2'd0;
            ops    <= '0;
            seg    <= 2'd0;
            mode_r <= MODE_A;
            done   <= 1'b0;
        end else begin
            state  <= state_n;
            q      <= q_n;
            ops    <= ops_n;
            seg    <= seg_n;
            mode_r <= mode_n;
            done   <= done_n;
        end
    end

    always_comb begin
        scl_oe = 1'b0;
        sda_oe = 1'b0;
        unique case (state)
            K_IDLE: begin
                scl_oe = 1'b0;
                sda_oe = 1'b0;
            end
            K_DUMMY: begin
                scl_oe = (q == 2'd0) || (q == 2'd3);
                sda_oe = 1'b0;
            end
            K_START: begin
                scl_oe = (q == 2'd0) || (q == 2'd3);
                sda_oe = q[1];
            end
            K_FINISH: begin
                scl_oe = 1'b0;
                sda_oe = (q == 2'd0);
            end
        endcase
    end
endmodule

// File: rtl/recov_seq.sv
module recov_seq
    import recov_pkg::*;
#(
    parameter int DIV      = 4,
    parameter int A_CLOCKS = 14,
    parameter int B_CLOCKS = 9,
    parameter int C_STARTS = 9
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start_i,
    input  logic [1:0] mode_i,
    output logic       scl_oe_o,
    output logic       sda_oe_o,
    output logic       done_o
);
    localparam int MAX_AB = (A_CLOCKS > B_CLOCKS) ? A_CLOCKS : B_CLOCKS;
    localparam int MAX_N  = (MAX_AB > C_STARTS) ? MAX_AB : C_STARTS;
    localparam int CW     = $clog2(MAX_N + 1);

    logic          tick;
    logic          busy;
    logic          accept;
    logic          is_dummy;
    logic [1:0]    mode_sel;
    logic [1:0]    seg;
    rk_e           cur_kind;
    rk_e           nxt_kind;
    logic [CW-1:0] cur_cnt;

    recov_tick #(.DIV(DIV)) u_tick (
        .clk  (clk),
        .rst_n(rst_n),
        .en   (busy),
        .tick (tick)
    );

    recov_prog #(
        .A_CLOCKS(A_CLOCKS),
        .B_CLOCKS(B_CLOCKS),
        .C_STARTS(C_STARTS),
        .CW      (CW)
    ) u_prog (
        .mode    (mode_sel),
        .seg     (seg),
        .cur_kind(cur_kind),
        .cur_cnt (cur_cnt),
        .nxt_kind(nxt_kind)
    );

    recov_fsm #(.CW(CW)) u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (start_i),
        .mode_i  (mode_i),
        .tick    (tick),
        .cur_kind(cur_kind),
        .cur_cnt (cur_cnt),
        .nxt_kind(nxt_kind),
        .mode_sel(mode_sel),
        .seg     (seg),
        .busy    (busy),
        .accept  (accept),
        .is_dummy(is_dummy),
        .scl_oe  (scl_oe_o),
        .sda_oe  (sda_oe_o),
        .done    (done_o)
    );
endmodule

// File: rtl/recov_seq_chk.sv
module recov_seq_chk (
    input logic clk,
    input logic rst_n,
    input logic scl_oe,
    input logic sda_oe,
    input logic done,
    input logic tick,
    input logic accept,
    input logic is_dummy
);
    // R4: data line left to its pull-up through every dummy clock
    p_dummy_sda_released_r4: assert property (@(posedge clk) disable iff (!rst_n)
        is_dummy |-> !sda_oe);

    // R5: line movement only follows a prescaler tick or an accepted request
    p_move_on_tick_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(scl_oe) || !$stable(sda_oe)) |-> ($past(tick) || $past(accept)));

    // R6: completion pulse lasts one clock
    p_done_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R7: bus idle when completion is reported
    p_idle_at_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!scl_oe && !sda_oe));

    // R11: never both lines in one clock
    p_one_line_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !(!$stable(scl_oe) && !$stable(sda_oe)));
endmodule

bind recov_seq recov_seq_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .scl_oe  (scl_oe_o),
    .sda_oe  (sda_oe_o),
    .done    (done_o),
    .tick    (tick),
    .accept  (accept),
    .is_dummy(is_dummy)
);

// File: tb/recov_seq_tb.sv
module recov_seq_tb;
    localparam int DIV = 3;
    localparam int EV_D = 1;
    localparam int EV_S = 2;
    localparam int EV_P = 3;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start_i = 1'b0;
    logic [1:0] mode_i = 2'b00;
    logic       scl_oe_o;
    logic       sda_oe_o;
    logic       done_o;

    int errors = 0;
    int checks = 0;

    always #5 clk = ~clk;

    recov_seq #(.DIV(DIV)) u_dut (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (start_i),
        .mode_i  (mode_i),
        .scl_oe_o(scl_oe_o),
        .sda_oe_o(sda_oe_o),
        .done_o  (done_o)
    );

    // line activity decoder
    bit observe = 1'b0;
    bit high = 1'b0;
    bit chg = 1'b0;
    bit bad_dummy = 1'b0;
    logic p_scl = 1'b0;
    logic p_sda = 1'b0;
    int ev [0:63];
    int ev_n = 0;

    task automatic push(input int code);
        if (ev_n < 64) ev[ev_n] = code;
        ev_n++;
    endtask

    always @(negedge clk) begin
        if (observe) begin
            if (p_scl && !scl_oe_o) begin
                high = 1'b1;
                chg  = 1'b0;
            end else if (!p_scl && scl_oe_o) begin
                if (high && !chg) begin
                    if (!sda_oe_o) push(EV_D);
                    else bad_dummy = 1'b1;
                end
                high = 1'b0;
            end
            if (high && !p_scl && !scl_oe_o && (p_sda != sda_oe_o)) begin
                push(sda_oe_o ? EV_S : EV_P);
                chg = 1'b1;
            end
        end
        p_scl = scl_oe_o;
        p_sda = sda_oe_o;
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic build_exp(input logic [1:0] m, output int e [0:63], output int n);
        n = 0;
        if (m == 2'b00) begin
            for (int i = 0; i < 14; i++) begin e[n] = EV_D; n++; end
            e[n] = EV_S; n++;
            e[n] = EV_S; n++;
        end else if (m == 2'b01) begin
            e[n] = EV_S; n++;
            for (int i = 0; i < 9; i++) begin e[n] = EV_D; n++; end
            e[n] = EV_S; n++;
        end else begin
            for (int i = 0; i < 9; i++) begin e[n] = EV_S; n++; end
        end
        e[n] = EV_P; n++;
    endtask

    task automatic run_mode(input logic [1:0] m, input bit poke, input string req);
        int e [0:63];
        int en;
        int prims;
        int n;
        int mism;
        build_exp(m, e, en);
        prims = en - 1;
        ev_n = 0; high = 1'b0; chg = 1'b0; bad_dummy = 1'b0;
        @(negedge clk);
        start_i = 1'b1; mode_i = m; observe = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        n = 0;
        while (!done_o && n < 5000) begin
            @(negedge clk);
            n++;
            if (poke && n == 10) begin start_i = 1'b1; mode_i = 2'b10; end
            if (poke && n == 11) start_i = 1'b0;
        end
        // R5: done at edge (4*primitives+2)*DIV after accept
        check(n == (4 * prims + 2) * DIV, {req, "/R5 length"}, n, (4 * prims + 2) * DIV);
        // R7: both released when done
        check(!scl_oe_o && !sda_oe_o, {req, "/R7 idle"}, {scl_oe_o, sda_oe_o}, 0);
        // R4: no dummy clock with SDA held low
        check(!bad_dummy, {req, "/R4 dummy sda"}, bad_dummy, 0);
        @(negedge clk);
        // R6: single-cycle done
        check(!done_o, {req, "/R6 done width"}, done_o, 0);
        observe = 1'b0;
        check(ev_n == en, {req, " event count"}, ev_n, en);
        mism = 0;
        for (int i = 0; i < en && i < ev_n; i++) if (ev[i] != e[i]) mism++;
        check(mism == 0, {req, " event order"}, mism, 0);
        repeat (3) @(negedge clk);
        // R8: no second done after an ignored request
        check(!done_o && !scl_oe_o, {req, "/R8 quiet after"}, {done_o, scl_oe_o}, 0);
    endtask

    initial begin
        #(200000 * 10);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R10: reset state
        check(!scl_oe_o && !sda_oe_o && !done_o, "R10 in reset", {scl_oe_o, sda_oe_o, done_o}, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check(!scl_oe_o && !sda_oe_o && !done_o, "R10 after reset", {scl_oe_o, sda_oe_o, done_o}, 0);

        run_mode(2'b00, 1'b0, "R1");
        run_mode(2'b01, 1'b0, "R2");
        run_mode(2'b10, 1'b0, "R3");
        run_mode(2'b00, 1'b1, "R8 busy A");
        run_mode(2'b01, 1'b1, "R8 busy B");

        // R9: invalid mode ignored
        begin
            int act;
            act = 0;
            @(negedge clk);
            start_i = 1'b1; mode_i = 2'b11;
            @(negedge clk);
            start_i = 1'b0;
            for (int i = 0; i < 60; i++) begin
                @(negedge clk);
                if (scl_oe_o || sda_oe_o || done_o) act++;
            end
            check(act == 0, "R9 invalid mode", act, 0);
        end

        run_mode(2'b10, 1'b0, "R3 again");

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule